// File: doc/BRIEF.md
# Looped Block Transfer Sequencer

This block steers multi-word block moves that are built by running one block-transfer microinstruction in a loop. The block holds four pointer registers. Pointer 1 is the word counter. Pointer 0 is an auxiliary pointer, which in chained-load mode holds the chain flag and the destination group. Pointers 2 and 3 together form a 16-bit address counter, with pointer 2 as the high byte. Each time the loop instruction executes, the block decides whether control branches back to the loop head or falls through to the continuation address. It drives the read and write strobes for the selected transfer, along with the destination address and group. It also keeps a bus-busy flag that a streaming device can hold across words.

In chained-load mode the block reads self-describing blocks from a 32-bit input bus. An execution that finds the word counter at zero treats the incoming word as a header, and that header reloads all four pointers. The executions that follow scatter data words into the group the header named. A block whose chain flag is set sends control back for another header once its words are used up. A block whose chain flag is clear exits to the continuation address.

Input data uses a valid/ready handshake. While `step_i` is high and the selected transfer consumes an input word, `in_ready_o` is high. The execution completes (`done_o`) only in a cycle where `in_valid_i` is also high. While it waits, nothing in the block changes. The source may hold `in_valid_i` high for any length of time, and a word counts as consumed only in a cycle where both signals are high. Transfers that take no input complete in the cycle that `step_i` is high.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, all four pointers, the status register and the bus-busy flag are zero, and no strobe or `done_o` is active while `step_i` is low.
- R2: `code_i` selects the transfer, and its strobes fire only in a completing cycle. 0 fires `cm_rd_o`. 1 fires `cm_wr_o` with `bad_parity_o` low. 2 fires `sb_rd_o`. 3 fires `sb_wr_o`. 4 fires `oe_move_o`. 5 fires `cm_wr_o` with `bad_parity_o` high. 6 is chained load. 7 completes with no strobe, no pointer change and no branch.
- R3: For codes 0 to 5, each execution decrements the word counter, the auxiliary pointer and the 16-bit address counter by one, each wrapping modulo its width. A borrow out of pointer 3 decrements pointer 2.
- R4: For codes 0 to 5, a word counter of one gives `branch_o`=0 and `next_addr_o`=`cont_addr_i`. Any other value gives `branch_o`=1 and `next_addr_o` = `cont_addr_i` plus the sign-extended `offset_i`, modulo 2^16.
- R5: A word counter that starts at zero in codes 0 to 5 runs exactly 256 executions before the first fall-through.
- R6: Codes 1, 3, 5 and 6 need an input word. For these, `in_ready_o` equals `step_i`, and while `in_valid_i` is low there is no `done_o` and no pointer change. Codes 0, 2, 4 and 7 keep `in_ready_o` low.
- R7: `wr_data_o` carries `in_data_i` for writes to control memory and to groups. For subroutine-stack writes it carries only bits 15:0, zero-extended.
- R8: A code-6 execution with the word counter at zero loads a header. Bits 31:24 go to pointer 0 (bit 28 is the chain flag, bits 27:24 the group). Bits 23:16 go to the word counter, and bits 15:0 go to the address counter. No group write takes place, and control branches to the relative target.
- R9: A code-6 execution with a non-zero word counter writes the word (`grp_wr_o`) to group `dst_group_o` at `dst_addr_o`. It then decrements the word counter and the address counter but leaves pointer 0 unchanged.
- R10: In code 6 with a non-zero counter, a clear chain flag together with a counter of one falls through to `cont_addr_i`. A set chain flag branches to the relative target, and the next execution then reads a header.
- R11: A code-6 data word to group 0xA loads bits 15:0 into the status register. With the chain flag clear, it also becomes `next_addr_o`, and `branch_o` is 1. With the chain flag set, the address load is blocked and the relative target is used.
- R12: `cmd_issue_i` sets bus busy. Consuming an input word clears it, unless `stream_i` is high and the word counter is not one.
- R13: With `step_i` low, `ptr_we_i` writes `ptr_wdata_i` into the pointer chosen by `ptr_sel_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_we_i | input | 1 | Pointer preset write |
| ptr_sel_i | input | 2 | Pointer index for the preset |
| ptr_wdata_i | input | 8 | Preset value |
| step_i | input | 1 | Execute the loop instruction |
| code_i | input | 3 | Transfer selection |
| stream_i | input | 1 | Keep bus busy across words |
| offset_i | input | 8 | Signed branch offset |
| cont_addr_i | input | 16 | Continuation address |
| cmd_issue_i | input | 1 | Command sent, sets bus busy |
| in_data_i | input | 32 | Input data word |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word accepted when valid |
| done_o | output | 1 | Execution completes this cycle |
| branch_o | output | 1 | Branch taken |
| next_addr_o | output | 16 | Address of the next instruction |
| dst_addr_o | output | 16 | Address counter value |
| dst_group_o | output | 4 | Destination group (pointer 0 bits 3:0) |
| cm_rd_o | output | 1 | Control memory read |
| cm_wr_o | output | 1 | Control memory write |
| bad_parity_o | output | 1 | Write with forced bad parity |
| sb_rd_o | output | 1 | Subroutine stack read |
| sb_wr_o | output | 1 | Subroutine stack write |
| oe_move_o | output | 1 | Operating-engine internal move |
| grp_wr_o | output | 1 | Chained-load group write |
| wr_data_o | output | 32 | Write data |
| status_o | output | 16 | Status register |
| bus_busy_o | output | 1 | Bus busy flag |
| wcount_o | output | 8 | Word counter |
| aux_o | output | 8 | Auxiliary pointer |

## Verification
The assertions watch several rules on every cycle. At most one strobe fires at a time, and bad parity never appears without a memory write. A stalled input handshake leaves the pointers frozen. Every fall-through outside chained load happens with a word count of one. Decrements happen by one, pointer 0 stays put during chained-load data, a blocked address load uses the relative target, and bus busy is not lost without a consumed word or a reset. The bench scenarios are needed for the rest: the 256-word run from a zero count, the address borrow, the exact branch targets with wrap, the header field positions, the chained hand-back to a header, and the status and address load.

// File: rtl/bts_pkg.sv
package bts_pkg;
  typedef enum logic [2:0] {
    XF_CM_RD   = 3'd0,
    XF_CM_WR   = 3'd1,
    XF_SB_RD   = 3'd2,
    XF_SB_WR   = 3'd3,
    XF_OE_MOVE = 3'd4,
    XF_CM_BAD  = 3'd5,
    XF_CHAIN   = 3'd6,
    XF_NONE    = 3'd7
  } xfer_e;

  localparam int GRP_W      = 4;
  localparam int CHAIN_BIT  = 4;
  localparam logic [GRP_W-1:0] GRP_STATUS = 4'hA;
  localparam int SB_DATA_W  = 16;
endpackage

// File: rtl/bts_ptr_file.sv
module bts_ptr_file #(
  parameter int PTR_W = 8,
  localparam int WORD_W = 4 * PTR_W,
  localparam int ADDR_W = 2 * PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_we,
  input  logic [1:0]        init_sel,
  input  logic [PTR_W-1:0]  init_data,
  input  logic              hdr_load,
  input  logic [WORD_W-1:0] hdr_word,
  input  logic              dec_wc,
  input  logic              dec_aux,
  input  logic              dec_addr,
  output logic [PTR_W-1:0]  wc,
  output logic [PTR_W-1:0]  aux,
  output logic [ADDR_W-1:0] addr
);
  logic [PTR_W-1:0] ptr_q [4];
  logic [ADDR_W-1:0] addr_dec;

  assign aux      = ptr_q[0];
  assign wc       = ptr_q[1];
  assign addr     = {ptr_q[2], ptr_q[3]};
  assign addr_dec = addr - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) ptr_q[i] <= '0;
    end else if (hdr_load) begin
      for (int i = 0; i < 4; i++) ptr_q[i] <= hdr_word[(4-i)*PTR_W-1 -: PTR_W];
    end else if (dec_wc || dec_aux || dec_addr) begin
      if (dec_aux) ptr_q[0] <= ptr_q[0] - 1'b1;
      if (dec_wc)  ptr_q[1] <= ptr_q[1] - 1'b1;
      if (dec_addr) begin
        ptr_q[2] <= addr_dec[ADDR_W-1:PTR_W];
        ptr_q[3] <= addr_dec[PTR_W-1:0];
      end
    end else if (init_we) begin
      ptr_q[init_sel] <= init_data;
    end
  end

  assert_dec_wc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_wc && !hdr_load |=> wc == $past(wc) - 1'b1);
  assert_dec_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_addr && !hdr_load |=> addr == $past(addr) - 1'b1);
endmodule

// File: rtl/bts_decode.sv
module bts_decode
  import bts_pkg::*;
(
  input  logic [2:0] code,
  input  logic       fire,
  input  logic       wc_zero,
  output logic       needs_in,
  output logic       cm_rd,
  output logic       cm_wr,
  output logic       bad_par,
  output logic       sb_rd,
  output logic       sb_wr,
  output logic       oe_move,
  output logic       grp_wr,
  output logic       hdr_load,
  output logic       dec_wc,
  output logic       dec_aux,
  output logic       dec_addr
);
  xfer_e xf;
  logic  single;
  logic  chain_data;

  assign xf         = xfer_e'(code);
  assign single     = (xf != XF_CHAIN) && (xf != XF_NONE);
  assign chain_data = (xf == XF_CHAIN) && !wc_zero;

  always_comb begin
    needs_in = 1'b0;
    unique case (xf)
      XF_CM_WR, XF_SB_WR, XF_CM_BAD, XF_CHAIN: needs_in = 1'b1;
      default:                                 needs_in = 1'b0;
    endcase
  end

  assign cm_rd    = fire && (xf == XF_CM_RD);
  assign cm_wr    = fire && ((xf == XF_CM_WR) || (xf == XF_CM_BAD));
  assign bad_par  = fire && (xf == XF_CM_BAD);
  assign sb_rd    = fire && (xf == XF_SB_RD);
  assign sb_wr    = fire && (xf == XF_SB_WR);
  assign oe_move  = fire && (xf == XF_OE_MOVE);
  assign grp_wr   = fire && chain_data;
  assign hdr_load = fire && (xf == XF_CHAIN) && wc_zero;
  assign dec_wc   = fire && (single || chain_data);
  assign dec_aux  = fire && single;
  assign dec_addr = fire && (single || chain_data);
endmodule

// File: rtl/bts_branch.sv
module bts_branch
  import bts_pkg::*;
#(
  parameter int PTR_W = 8,
  localparam int ADDR_W = 2 * PTR_W
) (
  input  logic [2:0]        code,
  input  logic [PTR_W-1:0]  wc,
  input  logic              chain,
  input  logic [GRP_W-1:0]  group,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [ADDR_W-1:0] cont_addr,
  input  logic [7:0]        offset,
  output logic              branch,
  output logic [ADDR_W-1:0] next_addr
);
  logic [ADDR_W-1:0] rel_tgt;
  logic              wc_one;
  logic              wc_zero;

  assign rel_tgt = cont_addr + {{(ADDR_W-8){offset[7]}}, offset};
  assign wc_one  = (wc == PTR_W'(1));
  assign wc_zero = (wc == '0);

  always_comb begin
    branch    = 1'b1;
    next_addr = rel_tgt;
    if (xfer_e'(code) == XF_NONE) begin
      branch    = 1'b0;
      next_addr = cont_addr;
    end else if (xfer_e'(code) == XF_CHAIN) begin
      if (wc_zero) begin
        branch    = 1'b1;
        next_addr = rel_tgt;
      end else if ((group == GRP_STATUS) && !chain) begin
        branch    = 1'b1;
        next_addr = load_addr;
      end else if (!chain && wc_one) begin
        branch    = 1'b0;
        next_addr = cont_addr;
      end
    end else if (wc_one) begin
      branch    = 1'b0;
      next_addr = cont_addr;
    end
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import bts_pkg::*;
#(
  parameter int PTR_W = 8,
  localparam int WORD_W = 4 * PTR_W,
  localparam int ADDR_W = 2 * PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_we_i,
  input  logic [1:0]        ptr_sel_i,
  input  logic [PTR_W-1:0]  ptr_wdata_i,
  input  logic              step_i,
  input  logic [2:0]        code_i,
  input  logic              stream_i,
  input  logic [7:0]        offset_i,
  input  logic [ADDR_W-1:0] cont_addr_i,
  input  logic              cmd_issue_i,
  input  logic [WORD_W-1:0] in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic              done_o,
  output logic              branch_o,
  output logic [ADDR_W-1:0] next_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic [GRP_W-1:0]  dst_group_o,
  output logic              cm_rd_o,
  output logic              cm_wr_o,
  output logic              bad_parity_o,
  output logic              sb_rd_o,
  output logic              sb_wr_o,
  output logic              oe_move_o,
  output logic              grp_wr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic [ADDR_W-1:0] status_o,
  output logic              bus_busy_o
  ,
  output logic [PTR_W-1:0]  wcount_o,
  output logic [PTR_W-1:0]  aux_o
);
  logic needs_in, fire, hdr_load, dec_wc, dec_aux, dec_addr;
  logic [PTR_W-1:0]  wc, aux;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] status_q;
  logic              busy_q;
  logic              consumed;

  assign in_ready_o = step_i && needs_in;
  assign fire       = step_i && (!needs_in || in_valid_i);
  assign done_o     = fire;
  assign consumed   = in_ready_o && in_valid_i;

  bts_decode u_dec (
    .code(code_i), .fire(fire), .wc_zero(wc == '0), .needs_in(needs_in),
    .cm_rd(cm_rd_o), .cm_wr(cm_wr_o), .bad_par(bad_parity_o),
    .sb_rd(sb_rd_o), .sb_wr(sb_wr_o), .oe_move(oe_move_o), .grp_wr(grp_wr_o),
    .hdr_load(hdr_load), .dec_wc(dec_wc), .dec_aux(dec_aux), .dec_addr(dec_addr)
  );

  bts_ptr_file #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .init_we(ptr_we_i && !step_i), .init_sel(ptr_sel_i), .init_data(ptr_wdata_i),
    .hdr_load(hdr_load), .hdr_word(in_data_i),
    .dec_wc(dec_wc), .dec_aux(dec_aux), .dec_addr(dec_addr),
    .wc(wc), .aux(aux), .addr(addr)
  );

  bts_branch #(.PTR_W(PTR_W)) u_br (
    .code(code_i), .wc(wc), .chain(aux[CHAIN_BIT]), .group(aux[GRP_W-1:0]),
    .load_addr(in_data_i[ADDR_W-1:0]), .cont_addr(cont_addr_i), .offset(offset_i),
    .branch(branch_o), .next_addr(next_addr_o)
  );

  assign dst_addr_o  = addr;
  assign dst_group_o = aux[GRP_W-1:0];
  assign wcount_o    = wc;
  assign aux_o       = aux;
  assign wr_data_o   = sb_wr_o ? {{(WORD_W-SB_DATA_W){1'b0}}, in_data_i[SB_DATA_W-1:0]}
                               : in_data_i;

  always_ff @(posedge clk) begin
    if (!rst_n)                                       status_q <= '0;
    else if (grp_wr_o && (aux[GRP_W-1:0] == GRP_STATUS)) status_q <= in_data_i[ADDR_W-1:0];
  end
  assign status_o = status_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                                            busy_q <= 1'b0;
    else if (cmd_issue_i)                                  busy_q <= 1'b1;
    else if (consumed && (!stream_i || wc == PTR_W'(1)))   busy_q <= 1'b0;
  end
  assign bus_busy_o = busy_q;

  assert_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o |-> step_i);
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o && !in_valid_i && !ptr_we_i |=> $stable(wcount_o) && $stable(dst_addr_o));
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cm_rd_o, cm_wr_o, sb_rd_o, sb_wr_o, oe_move_o, grp_wr_o}));
  assert_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bad_parity_o |-> cm_wr_o);
  assert_exit_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !branch_o && code_i < 3'd6 |-> wcount_o == PTR_W'(1));
  assert_aux_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grp_wr_o && !ptr_we_i |=> $stable(aux_o));
  assert_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    grp_wr_o && aux_o[CHAIN_BIT] |->
      next_addr_o == cont_addr_i + {{(ADDR_W-8){offset_i[7]}}, offset_i});
  assert_busy_keep_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy_o && !consumed |=> bus_busy_o);
endmodule

// File: tb/test_blk_xfer_seq.sv
module test_blk_xfer_seq;
  logic clk = 0, rst_n = 0;
  logic ptr_we_i = 0; logic [1:0] ptr_sel_i = 0; logic [7:0] ptr_wdata_i = 0;
  logic step_i = 0; logic [2:0] code_i = 0; logic stream_i = 0;
  logic [7:0] offset_i = 0; logic [15:0] cont_addr_i = 0; logic cmd_issue_i = 0;
  logic [31:0] in_data_i = 0; logic in_valid_i = 0;
  logic in_ready_o, done_o, branch_o, cm_rd_o, cm_wr_o, bad_parity_o, sb_rd_o, sb_wr_o;
  logic oe_move_o, grp_wr_o, bus_busy_o;
  logic [15:0] next_addr_o, dst_addr_o, status_o; logic [3:0] dst_group_o;
  logic [31:0] wr_data_o; logic [7:0] wcount_o, aux_o;

  int checks = 0, errors = 0; bit finished = 0;
  logic s_done, s_branch, s_ready; logic [15:0] s_next, s_daddr; logic [3:0] s_grp;
  logic [6:0] s_strb; logic s_bad; logic [31:0] s_wdata;

  always #5 clk = ~clk;

  blk_xfer_seq i_blk_xfer_seq (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rel(input logic [15:0] c, input logic [7:0] o);
    return c + {{8{o[7]}}, o};
  endfunction

  task automatic preset(input logic [7:0] p0, p1, p2, p3);
    logic [7:0] v [4];
    v[0] = p0; v[1] = p1; v[2] = p2; v[3] = p3;
    for (int i = 0; i < 4; i++) begin
      ptr_we_i = 1; ptr_sel_i = 2'(i); ptr_wdata_i = v[i];
      @(negedge clk);
    end
    ptr_we_i = 0;
  endtask

  task automatic exec(input logic [2:0] c, input logic [31:0] d, input int stall);
    step_i = 1; code_i = c; in_data_i = d; in_valid_i = 0;
    for (int k = 0; k < stall; k++) begin
      logic [7:0] wc0;
      #1; wc0 = wcount_o;
      check("R6 stall ready", in_ready_o, 1'b1);
      check("R6 stall no done", done_o, 1'b0);
      @(negedge clk);
      check("R6 stall pointers held", wcount_o, wc0);
    end
    in_valid_i = 1; #1;
    s_done = done_o; s_branch = branch_o; s_next = next_addr_o; s_daddr = dst_addr_o;
    s_grp = dst_group_o; s_ready = in_ready_o; s_bad = bad_parity_o; s_wdata = wr_data_o;
    s_strb = {grp_wr_o, oe_move_o, sb_wr_o, sb_rd_o, cm_wr_o, cm_rd_o, 1'b0};
    @(negedge clk);
    step_i = 0; in_valid_i = 0;
  endtask

  task automatic t_reset;
    check("R1 wcount", wcount_o, 0); check("R1 aux", aux_o, 0);
    check("R1 addr", dst_addr_o, 0); check("R1 status", status_o, 0);
    check("R1 busy", bus_busy_o, 0); check("R1 done", done_o, 0);
    check("R1 strobes", {cm_rd_o, cm_wr_o, sb_rd_o, sb_wr_o, oe_move_o, grp_wr_o}, 0);
  endtask

  task automatic t_loop_read;
    cont_addr_i = 16'h0100; offset_i = 8'hF0;
    preset(8'h05, 8'h03, 8'h12, 8'h00);
    check("R13 preset wcount", wcount_o, 8'h03);
    check("R13 preset addr", dst_addr_o, 16'h1200);
    exec(3'd0, 0, 0);
    check("R6 read ready low", s_ready, 0);
    check("R2 cm read strobe", s_strb, 7'b0000010);
    check("R4 branch taken", s_branch, 1);
    check("R4 backward target", s_next, 16'h00F0);
    check("R3 wcount dec", wcount_o, 8'h02);
    check("R3 aux dec", aux_o, 8'h04);
    check("R3 addr borrow", dst_addr_o, 16'h11FF);
    exec(3'd0, 0, 0);
    check("R4 second branch", s_branch, 1);
    exec(3'd0, 0, 0);
    check("R4 exit at one", s_branch, 0);
    check("R4 exit address", s_next, 16'h0100);
    check("R3 wcount zero", wcount_o, 0);
  endtask

  task automatic t_zero_count;
    int n = 0; bit out = 0;
    cont_addr_i = 16'hFFF0; offset_i = 8'h7F;
    preset(8'h00, 8'h00, 8'h00, 8'h00);
    exec(3'd2, 0, 0); n++;
    check("R2 sb read strobe", s_strb, 7'b0001000);
    check("R4 wrap target", s_next, 16'h006F);
    while (!out && n < 300) begin
      exec(3'd2, 0, 0); n++;
      if (!s_branch) out = 1;
    end
    check("R5 256 words", n, 256);
  endtask

  task automatic t_writes;
    cont_addr_i = 16'h0300; offset_i = 8'h02;
    preset(8'h00, 8'h09, 8'h00, 8'h10);
    exec(3'd1, 32'hCAFE1234, 3);
    check("R2 cm write", s_strb, 7'b0000100);
    check("R2 good parity", s_bad, 0);
    check("R7 cm data", s_wdata, 32'hCAFE1234);
    check("R6 done after valid", s_done, 1);
    exec(3'd5, 32'h0BAD0001, 1);
    check("R2 bad parity write", {s_strb, s_bad}, {7'b0000100, 1'b1});
    exec(3'd3, 32'hDEAD5678, 0);
    check("R2 sb write", s_strb, 7'b0010000);
    check("R7 sb low half", s_wdata, 32'h00005678);
    exec(3'd4, 0, 0);
    check("R2 oe move", s_strb, 7'b0100000);
    check("R3 wcount after four", wcount_o, 8'h05);
    exec(3'd7, 0, 0);
    check("R2 none no strobe", {s_strb, s_branch, s_next}, {7'b0, 1'b0, 16'h0300});
    check("R2 none keeps count", wcount_o, 8'h05);
  endtask

  task automatic t_chain;
    cont_addr_i = 16'h0400; offset_i = 8'hFC;
    preset(8'h00, 8'h00, 8'h00, 8'h00);
    exec(3'd6, 32'h13020040, 0);
    check("R8 header branch", {s_branch, s_next}, {1'b1, 16'h03FC});
    check("R8 header no write", s_strb, 0);
    check("R8 aux loaded", aux_o, 8'h13);
    check("R8 count loaded", wcount_o, 8'h02);
    check("R8 addr loaded", dst_addr_o, 16'h0040);
    exec(3'd6, 32'h11111111, 0);
    check("R9 group write", s_strb, 7'b1000000);
    check("R9 group and addr", {s_grp, s_daddr}, {4'h3, 16'h0040});
    check("R9 aux kept", aux_o, 8'h13);
    check("R9 count and addr dec", {wcount_o, dst_addr_o}, {8'h01, 16'h003F});
    exec(3'd6, 32'h22222222, 0);
    check("R10 chained branch back", {s_branch, s_next}, {1'b1, 16'h03FC});
    check("R10 count at header", wcount_o, 0);
    exec(3'd6, 32'h05010200, 0);
    check("R10 second header", {aux_o, wcount_o, dst_addr_o}, {8'h05, 8'h01, 16'h0200});
    exec(3'd6, 32'h33333333, 0);
    check("R10 last block exits", {s_branch, s_next}, {1'b0, 16'h0400});
  endtask

  task automatic t_status;
    cont_addr_i = 16'h0500; offset_i = 8'h10;
    preset(8'h00, 8'h00, 8'h00, 8'h00);
    exec(3'd6, 32'h1A010000, 0);
    exec(3'd6, 32'h0000BEEF, 0);
    check("R11 blocked load", {s_branch, s_next}, {1'b1, 16'h0510});
    check("R11 status loaded", status_o, 16'hBEEF);
    exec(3'd6, 32'h0A010000, 0);
    exec(3'd6, 32'h00001234, 0);
    check("R11 address load", {s_branch, s_next}, {1'b1, 16'h1234});
    check("R11 status second", status_o, 16'h1234);
  endtask

  task automatic t_stream;
    preset(8'h00, 8'h03, 8'h00, 8'h00);
    stream_i = 1; cmd_issue_i = 1; @(negedge clk); cmd_issue_i = 0;
    check("R12 busy set", bus_busy_o, 1);
    exec(3'd1, 1, 0); check("R12 stream hold 1", bus_busy_o, 1);
    exec(3'd1, 2, 0); check("R12 stream hold 2", bus_busy_o, 1);
    exec(3'd1, 3, 0); check("R12 cleared at one", bus_busy_o, 0);
    preset(8'h00, 8'h05, 8'h00, 8'h00);
    stream_i = 0; cmd_issue_i = 1; @(negedge clk); cmd_issue_i = 0;
    exec(3'd0, 0, 0); check("R12 read keeps busy", bus_busy_o, 1);
    exec(3'd1, 4, 0); check("R12 no stream clears", bus_busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    t_reset; t_loop_read; t_zero_count; t_writes; t_chain; t_status; t_stream;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule